// File: doc/BRIEF.md
# Serial ID Message Injector

This block places a fixed identification string on a serial transmit line that it shares with an existing UART transmitter. The string is stored as line-level bits, with every start and stop bit already in place, in a ring register that rotates once per baud tick. A second ring of the same length carries a single marker bit that reaches the end of the ring together with the final stop bit. A 2:1 selector hands the line either to the UART or to the ring output.

A send begins after reset when the `AUTO_SEND` parameter is set, and again whenever `cmd_send` is strobed while the block is idle. After a request, the block waits for the next baud tick so that the first start bit lasts a full bit period. The pattern then runs to its end, and the line goes back to the UART. Both rings make exactly one full turn per message, so every message starts again from its first start bit.

Top module: `serial_id_injector`

## Requirements
- R1: While `rst_n` is low, `busy` and `done` are 0 and `serial_out` equals `uart_txd`.
- R2: With `AUTO_SEND` = 1, one message is sent after reset is released without any command.
- R3: A one-cycle `cmd_send` pulse while `busy` is 0 sets `busy` on the next clock edge and leads to one message. This includes a pulse in the same cycle that `done` is high.
- R4: After a request, the line stays with the UART until the next `baud_tick` edge. From that edge on, one stored bit is shown per tick period.
- R5: Whenever no message is being shifted out, `serial_out` equals `uart_txd`, and baud ticks do not alter the stored pattern.
- R6: Each character is sent as a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Characters go in string order, with the most significant byte of `MSG_TEXT` first.
- R7: On the tick that ends the last stop bit, `busy` falls and the line returns to the UART. `done` is high for exactly one clock cycle after that edge.
- R8: A `cmd_send` pulse while `busy` is 1 is ignored: no extra message and no extra `done`.
- R9: Every message, however many idle ticks came before it, begins with the first start bit and repeats the same bit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle bit-period strobe shared with the UART transmitter |
| cmd_send | input | 1 | Request to send the ID message |
| uart_txd | input | 1 | Transmit line of the existing UART |
| serial_out | output | 1 | Shared serial line |
| busy | output | 1 | A request is armed or a message is being sent |
| done | output | 1 | One-cycle pulse after the message ends |

## Verification
Two events can fall on the same cycle: the end of one message, with `done` high, and a fresh `cmd_send`. The bench produces this by strobing `cmd_send` exactly in the cycle where it sees `done` high. It then expects a complete second message, decoded from the line, plus a second `done`. The bench also issues a request in the middle of a message and checks that it is dropped. It confirms this by requiring the decoded characters to match the queued string exactly, with nothing extra arriving afterwards.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int unsigned SID_DATA_BITS  = 8;
  localparam int unsigned SID_FRAME_BITS = SID_DATA_BITS + 2;

  typedef enum logic [1:0] {
    SID_IDLE  = 2'd0,
    SID_ARMED = 2'd1,
    SID_SEND  = 2'd2
  } sid_state_e;
endpackage

// File: rtl/sid_msg_ring.sv
module sid_msg_ring
  import sid_pkg::*;
#(
  parameter int unsigned              MSG_CHARS = 4,
  parameter logic [8*MSG_CHARS-1:0]   MSG_TEXT  = "ID26"
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic shift_en,
  output logic line_bit
);
  localparam int unsigned RING_LEN = MSG_CHARS * SID_FRAME_BITS;

  logic [RING_LEN-1:0] pattern;
  logic [RING_LEN-1:0] ring_q;
  logic [RING_LEN-1:0] ring_d;

  // Framed bit stream: index 0 leaves first.
  for (genvar c = 0; c < MSG_CHARS; c++) begin : g_frame
    localparam int unsigned BASE = c * SID_FRAME_BITS;
    assign pattern[BASE] = 1'b0;
    assign pattern[BASE+1 +: SID_DATA_BITS] =
      MSG_TEXT[SID_DATA_BITS*(MSG_CHARS-1-c) +: SID_DATA_BITS];
    assign pattern[BASE+SID_FRAME_BITS-1] = 1'b1;
  end

  always_comb begin
    ring_d = ring_q;
    if (shift_en) ring_d = {ring_q[0], ring_q[RING_LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ring_q <= pattern;
    else         ring_q <= ring_d;
  end

  assign line_bit = ring_q[0];
endmodule

// File: rtl/sid_end_ring.sv
module sid_end_ring #(
  parameter int unsigned RING_LEN = 40
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic shift_en,
  output logic last_bit
);
  logic [RING_LEN-1:0] mark_q;
  logic [RING_LEN-1:0] mark_d;

  always_comb begin
    mark_d = mark_q;
    if (shift_en) mark_d = {mark_q[0], mark_q[RING_LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mark_q <= {1'b1, {(RING_LEN-1){1'b0}}};
    else         mark_q <= mark_d;
  end

  assign last_bit = mark_q[0];

  AST_END_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones(mark_q) == 1); // R7
endmodule

// File: rtl/sid_launch_ctrl.sv
module sid_launch_ctrl
  import sid_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic baud_tick,
  input  logic start_req,
  input  logic last_bit,
  output logic sending,
  output logic shift_en,
  output logic busy,
  output logic done
);
  sid_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       finish;

  assign finish = (state_q == SID_SEND) && baud_tick && last_bit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SID_IDLE:  if (start_req) state_d = SID_ARMED;
      SID_ARMED: if (baud_tick) state_d = SID_SEND;
      SID_SEND:  if (finish)    state_d = SID_IDLE;
      default:                  state_d = SID_IDLE;
    endcase
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SID_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign sending  = (state_q == SID_SEND);
  assign shift_en = sending && baud_tick;
  assign busy     = (state_q != SID_IDLE);
  assign done     = done_q;

  AST_SEND_STARTS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sending) |-> $past(baud_tick)); // R4
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done); // R7
  AST_BUSY_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> done); // R7
  AST_REQ_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_ni)
    (sending && start_req && !(baud_tick && last_bit)) |=> sending); // R8
endmodule

// File: rtl/serial_id_injector.sv
module serial_id_injector
  import sid_pkg::*;
#(
  parameter int unsigned            MSG_CHARS = 4,
  parameter logic [8*MSG_CHARS-1:0] MSG_TEXT  = "ID26",
  parameter bit                     AUTO_SEND = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic cmd_send,
  input  logic uart_txd,
  output logic serial_out,
  output logic busy,
  output logic done
);
  localparam int unsigned RING_LEN = MSG_CHARS * SID_FRAME_BITS;

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       booted_q;
  logic       start_req;
  logic       sending;
  logic       shift_en;
  logic       last_bit;
  logic       id_bit;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) booted_q <= 1'b0;
    else         booted_q <= 1'b1;
  end

  assign start_req = cmd_send | (AUTO_SEND & ~booted_q);

  sid_launch_ctrl u_ctrl (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .baud_tick (baud_tick),
    .start_req (start_req),
    .last_bit  (last_bit),
    .sending   (sending),
    .shift_en  (shift_en),
    .busy      (busy),
    .done      (done)
  );

  sid_msg_ring #(
    .MSG_CHARS (MSG_CHARS),
    .MSG_TEXT  (MSG_TEXT)
  ) u_msg (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .shift_en (shift_en),
    .line_bit (id_bit)
  );

  sid_end_ring #(
    .RING_LEN (RING_LEN)
  ) u_end (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .shift_en (shift_en),
    .last_bit (last_bit)
  );

  assign serial_out = sending ? id_bit : uart_txd;

  AST_IDLE_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (serial_out == uart_txd)); // R5
  AST_OPENS_WITH_START_BIT: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sending) |-> (serial_out == 1'b0)); // R9
  AST_LAST_BIT_IS_STOP: assert property (@(posedge clk) disable iff (!rst_ni)
    (sending && last_bit) |-> (serial_out == 1'b1)); // R6
endmodule

// File: tb/serial_id_injector_tb.sv
module serial_id_injector_tb;
  localparam int unsigned      CHARS = 4;
  localparam logic [8*CHARS-1:0] TEXT = "ID26";
  localparam int unsigned      DIV   = 8;

  logic clk = 1'b0;
  logic rst_n, baud_tick, cmd_send, uart_txd;
  logic serial_out, busy, done;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int exp_done = 0;
  logic [7:0] exp_q [$];

  serial_id_injector #(
    .MSG_CHARS (CHARS),
    .MSG_TEXT  (TEXT),
    .AUTO_SEND (1'b1)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .cmd_send   (cmd_send),
    .uart_txd   (uart_txd),
    .serial_out (serial_out),
    .busy       (busy),
    .done       (done)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: queue the characters of one message.
  task automatic expect_msg();
    for (int c = 0; c < CHARS; c++) begin
      exp_q.push_back(TEXT[8*(CHARS-1-c) +: 8]);
    end
    exp_done++;
  endtask

  // Baud tick: one cycle every DIV clocks, changed away from the active edge.
  initial begin
    baud_tick = 1'b0;
    forever begin
      for (int i = 0; i < DIV; i++) begin
        @(negedge clk);
        baud_tick = (i == DIV - 1);
      end
    end
  end

  // Monitor: decode the line once per bit period, just before each tick edge.
  int         rx_pos = -1;
  logic [7:0] rx_sh  = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (baud_tick && busy && rst_n) begin
        if (rx_pos < 0) begin
          if (serial_out == 1'b0) rx_pos = 0;
        end else if (rx_pos < 8) begin
          rx_sh[rx_pos] = serial_out;
          rx_pos++;
        end else begin
          check(serial_out == 1'b1, "R6 stop bit", serial_out, 1);
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected character", rx_sh, -1);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(rx_sh == e, "R6 character", rx_sh, e);
          end
          rx_pos = -1;
        end
      end
    end
  end

  // done pulse counter and width check.
  logic done_prev = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (done && !done_prev) done_cnt++;
      if (done && done_prev) check(1'b0, "R7 done longer than one cycle", 2, 1);
      done_prev = done;
    end
  end

  task automatic wait_done(input string tag);
    int t;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!done && t < 3000);
    check(done == 1'b1, tag, done, 1);
    check(busy == 1'b0, "R7 busy low with done", busy, 0);
    check(serial_out == uart_txd, "R7 line back to UART", serial_out, uart_txd);
  endtask

  task automatic pulse_cmd();
    cmd_send = 1'b1;
    @(negedge clk);
    cmd_send = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_send = 1'b0; uart_txd = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    uart_txd = 1'b0; #1;
    check(serial_out == 1'b0, "R1 passthrough in reset", serial_out, 0);
    uart_txd = 1'b1; #1;
    check(serial_out == 1'b1, "R1 passthrough in reset", serial_out, 1);

    // R2: power-up message.
    expect_msg();
    @(negedge clk); rst_n = 1'b1;
    wait_done("R2 power-up message done");
    check(exp_q.size() == 0, "R2 all characters seen", exp_q.size(), 0);

    // R5: idle passthrough, ticks running.
    for (int i = 0; i < 40; i++) begin
      uart_txd = i[1] ^ i[0];
      @(negedge clk);
      check(serial_out == uart_txd && !busy, "R5 idle passthrough", serial_out, uart_txd);
    end
    uart_txd = 1'b1;

    // R3 / R4: command start, aligned to next tick.
    expect_msg();
    pulse_cmd();
    check(busy == 1'b1, "R3 busy after command", busy, 1);
    while (!baud_tick) begin
      check(serial_out == 1'b1, "R4 UART holds line while armed", serial_out, 1);
      @(negedge clk);
    end
    check(serial_out == 1'b1, "R4 UART holds line on tick cycle", serial_out, 1);
    @(negedge clk);
    check(serial_out == 1'b0, "R4 start bit after tick", serial_out, 0);

    // R8: request in mid-message is dropped.
    repeat (100) @(negedge clk);
    pulse_cmd();
    wait_done("R3 commanded message done");
    repeat (600) @(negedge clk);
    check(exp_q.size() == 0, "R8 no leftover characters", exp_q.size(), 0);
    check(done_cnt == exp_done, "R8 done count", done_cnt, exp_done);
    check(busy == 1'b0, "R8 idle after ignored request", busy, 0);

    // R9: after many idle ticks, the same stream again.
    expect_msg();
    pulse_cmd();
    wait_done("R9 repeat message done");
    check(exp_q.size() == 0, "R9 repeat characters", exp_q.size(), 0);

    // R3: request in the very cycle done is high.
    expect_msg();
    expect_msg();
    pulse_cmd();
    wait_done("R3 first of back-to-back");
    pulse_cmd();
    check(busy == 1'b1, "R3 request on done cycle accepted", busy, 1);
    wait_done("R3 second of back-to-back");
    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R3 back-to-back characters", exp_q.size(), 0);
    check(done_cnt == exp_done, "R7 total done pulses", done_cnt, exp_done);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule